// File: doc/BRIEF.md
# Single-Key Playlist Sequencer

This block turns a single debounced key pulse into playback commands for a sentence player. The playlist holds up to 32 sentences. A static mode input chooses how a press picks what to play. In chain mode, one press plays the whole list from index 0 upward. In step mode, each press plays one sentence and moves a pointer forward, wrapping at the end of the list. In shuffle mode, each press plays one sentence picked pseudo-randomly from the configured list.

The player reports the end of each sentence with a one-cycle done pulse. The sequencer answers with a one-cycle start strobe and a 5-bit index, or with a one-cycle stop strobe. An optional toggle input makes a press during playback stop it instead of being ignored. The list length and the mode are configuration inputs that are held steady while playback is active. All outputs are registered.

Top module: `keyseq_top`

## Requirements
- R1: While reset is high and in the cycle after it falls, `start_o` and `stop_o` are low, `start_idx` is 0 and the sequencer is idle. The first step-mode press after reset plays index 0.
- R2: A press while idle gives a start strobe exactly one cycle later. Both strobes last one cycle.
- R3: Chain mode (`mode` = 2'b00) works as follows. A press starts index 0. Each done pulse for an entry other than the last starts the next index one cycle later. A done pulse for the last entry (index length-1) issues no start and returns the sequencer to idle. The next press starts again from 0.
- R4: Step mode (`mode` = 2'b01) works as follows. Each press plays the pointer value and then advances the pointer, which wraps to 0 after length-1. If the pointer is not below the length, the press plays 0 and the pointer becomes 1 (or stays 0 when the length is 1). A done pulse returns the sequencer to idle and issues no start.
- R5: Shuffle mode (`mode` = 2'b10) plays one entry per press. Its index is always below the effective length, so it is always 0 when the length is 1.
- R6: With `toggle_en` high, a press while active gives a stop strobe one cycle later, with no start strobe, and returns the sequencer to idle. Done pulses after that start nothing.
- R7: With `toggle_en` low, a press while active is ignored. It produces no strobe, and a chain in progress continues on the next done pulse.
- R8: A press and a done pulse in the same cycle while active, with toggle enabled, give a stop and no start. A done pulse while idle is ignored.
- R9: `mode` 2'b11 behaves as step mode and shares its pointer. A `list_len` of 0 acts as 1, and any value above 32 acts as 32.
- R10: `start_o` and `stop_o` are never high together. `start_idx` changes only in a cycle in which `start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_pulse | input | 1 | Debounced one-cycle key press |
| play_done | input | 1 | One-cycle pulse from the player at the end of a sentence |
| mode | input | 2 | 00 chain, 01 step, 10 shuffle, 11 step |
| list_len | input | 6 | Number of playlist entries (1 to 32) |
| toggle_en | input | 1 | Press-again-to-stop enable |
| start_o | output | 1 | One-cycle start strobe to the player |
| start_idx | output | 5 | Index of the sentence to start; holds between starts |
| stop_o | output | 1 | One-cycle stop strobe to the player |

## Verification
A wrong active flag shows one cycle after the next press. The press then produces a start where a stop or silence was due, or the reverse. A corrupted chain index or step pointer shows in `start_idx` on the next start strobe: an index is skipped, repeated or fails to wrap. A broken shuffle scaler shows as an index at or above the list length, which is visible on the same strobe. A bench model of idle/active state, pointer and last index is updated each cycle from the port stimulus. Every strobe and index is compared one cycle after the stimulus that caused it.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;
  typedef enum logic [1:0] {
    MODE_CHAIN = 2'b00,
    MODE_STEP  = 2'b01,
    MODE_SHUF  = 2'b10,
    MODE_STEP2 = 2'b11
  } play_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ONE   = 2'b01,
    ST_CHAIN = 2'b10
  } seq_state_e;
endpackage

// File: rtl/keyseq_lfsr.sv
module keyseq_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // Galois form: shift right, fold the output bit into the tap positions
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign nxt[i] = TAPS[i] & q[0];
    end else begin : g_mid
      assign nxt[i] = q[i+1] ^ (TAPS[i] & q[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= {{(W-1){1'b0}}, 1'b1};
    else     q <= nxt;
  end
endmodule

// File: rtl/keyseq_pick.sv
module keyseq_pick #(
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 6,
  parameter int RND_W   = 16,
  parameter int SCALE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_eff,
  input  logic             adv,
  input  logic [RND_W-1:0] rnd,
  output logic [IDX_W-1:0] step_idx,
  output logic [IDX_W-1:0] rand_idx
);
  localparam int PROD_W = SCALE_W + LEN_W;

  logic [IDX_W-1:0]  ptr_q;
  logic [LEN_W-1:0]  ptr_ext;
  logic [PROD_W-1:0] prod;

  assign ptr_ext  = {{(LEN_W-IDX_W){1'b0}}, ptr_q};
  assign step_idx = (ptr_ext >= len_eff) ? '0 : ptr_q;

  // Fractional scaling: top bits of the LFSR times the length, keep the integer part
  assign prod     = PROD_W'(rnd[RND_W-1 -: SCALE_W]) * PROD_W'(len_eff);
  assign rand_idx = prod[SCALE_W +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv) begin
      if ({{(LEN_W-IDX_W){1'b0}}, step_idx} >= len_eff - LEN_W'(1)) ptr_q <= '0;
      else                                                           ptr_q <= step_idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/keyseq_ctrl.sv
module keyseq_ctrl
  import keyseq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_i,
  input  logic             done_i,
  input  logic [1:0]       mode_i,
  input  logic             toggle_i,
  input  logic [LEN_W-1:0] len_eff,
  input  logic [IDX_W-1:0] step_idx,
  input  logic [IDX_W-1:0] rand_idx,
  output logic             start_o,
  output logic             stop_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             adv_o,
  output logic             active_o,
  output logic             chain_o
);
  seq_state_e       state_q, state_d;
  logic             start_d, stop_d;
  logic [IDX_W-1:0] idx_d;
  logic             at_last;
  play_mode_e       md;

  assign md       = play_mode_e'(mode_i);
  assign at_last  = ({{(LEN_W-IDX_W){1'b0}}, idx_o} >= len_eff - LEN_W'(1));
  assign active_o = (state_q != ST_IDLE);
  assign chain_o  = (state_q == ST_CHAIN);

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    idx_d   = idx_o;
    adv_o   = 1'b0;
    if (state_q == ST_IDLE) begin
      if (key_i) begin
        start_d = 1'b1;
        unique case (md)
          MODE_CHAIN: begin
            idx_d   = '0;
            state_d = ST_CHAIN;
          end
          MODE_SHUF: begin
            idx_d   = rand_idx;
            state_d = ST_ONE;
          end
          default: begin
            idx_d   = step_idx;
            adv_o   = 1'b1;
            state_d = ST_ONE;
          end
        endcase
      end
    end else if (key_i && toggle_i) begin
      stop_d  = 1'b1;
      state_d = ST_IDLE;
    end else if (done_i) begin
      if (state_q == ST_CHAIN && !at_last) begin
        start_d = 1'b1;
        idx_d   = idx_o + IDX_W'(1);
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      idx_o   <= '0;
    end else begin
      state_q <= state_d;
      start_o <= start_d;
      stop_o  <= stop_d;
      idx_o   <= idx_d;
    end
  end
endmodule

// File: rtl/keyseq_top.sv
module keyseq_top #(
  parameter int IDX_W   = 5,
  parameter int RND_W   = 16,
  parameter int SCALE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                key_pulse,
  input  logic                play_done,
  input  logic [1:0]          mode,
  input  logic [IDX_W:0]      list_len,
  input  logic                toggle_en,
  output logic                start_o,
  output logic [IDX_W-1:0]    start_idx,
  output logic                stop_o
);
  localparam int LEN_W   = IDX_W + 1;
  localparam int MAX_LEN = 1 << IDX_W;

  logic [LEN_W-1:0] len_eff;
  logic [RND_W-1:0] rnd;
  logic [IDX_W-1:0] step_idx, rand_idx;
  logic             adv, seq_active, seq_chain;

  always_comb begin
    if (list_len == '0)                    len_eff = LEN_W'(1);
    else if (list_len > LEN_W'(MAX_LEN))   len_eff = LEN_W'(MAX_LEN);
    else                                   len_eff = list_len;
  end

  keyseq_lfsr #(.W(RND_W)) lfsr_i (
    .clk (clk), .rst (rst), .q (rnd)
  );

  keyseq_pick #(.IDX_W(IDX_W), .LEN_W(LEN_W), .RND_W(RND_W), .SCALE_W(SCALE_W)) pick_i (
    .clk      (clk),
    .rst      (rst),
    .len_eff  (len_eff),
    .adv      (adv),
    .rnd      (rnd),
    .step_idx (step_idx),
    .rand_idx (rand_idx)
  );

  keyseq_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .key_i    (key_pulse),
    .done_i   (play_done),
    .mode_i   (mode),
    .toggle_i (toggle_en),
    .len_eff  (len_eff),
    .step_idx (step_idx),
    .rand_idx (rand_idx),
    .start_o  (start_o),
    .stop_o   (stop_o),
    .idx_o    (start_idx),
    .adv_o    (adv),
    .active_o (seq_active),
    .chain_o  (seq_chain)
  );
endmodule

// File: rtl/keyseq_chk.sv
module keyseq_chk #(
  parameter int IDX_W = 5,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             key_pulse,
  input logic             play_done,
  input logic             toggle_en,
  input logic             start_o,
  input logic             stop_o,
  input logic [IDX_W-1:0] start_idx,
  input logic [LEN_W-1:0] len_eff,
  input logic             seq_active,
  input logic             seq_chain
);
  logic last_entry;
  assign last_entry = ({1'b0, start_idx} == len_eff - LEN_W'(1));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!start_o && !stop_o && start_idx == '0));

  assert_idle_press_R2: assert property (@(posedge clk) disable iff (rst)
    (!seq_active && key_pulse) |=> start_o);

  assert_chain_step_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_chain && play_done && !key_pulse && !last_entry)
      |=> (start_o && start_idx == $past(start_idx) + IDX_W'(1)));

  assert_chain_end_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_chain && play_done && !key_pulse && last_entry) |=> (!start_o && !seq_active));

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ({1'b0, start_idx} < len_eff));

  assert_toggle_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_active && key_pulse && toggle_en) |=> (stop_o && !start_o && !seq_active));

  assert_press_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (seq_active && key_pulse && !toggle_en && !play_done) |=> (!stop_o && !start_o));

  assert_idle_done_R8: assert property (@(posedge clk) disable iff (rst)
    (!seq_active && play_done && !key_pulse) |=> (!start_o && !stop_o));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o));

  assert_idx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(start_idx) |-> start_o);
endmodule

bind keyseq_top keyseq_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/keyseq_top_tb_top.sv
module keyseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_pulse = 1'b0;
  logic       play_done = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [5:0] list_len = 6'd3;
  logic       toggle_en = 1'b0;
  logic       start_o, stop_o;
  logic [4:0] start_idx;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // bench model of the sequencer
  bit m_act, m_chain;
  int m_idx, m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyseq_top dut_i (
    .clk (clk), .rst (rst), .key_pulse (key_pulse), .play_done (play_done),
    .mode (mode), .list_len (list_len), .toggle_en (toggle_en),
    .start_o (start_o), .start_idx (start_idx), .stop_o (stop_o)
  );

  function automatic int eff_len(input int v);
    if (v == 0) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic step(input bit k, input bit d, input string tag);
    bit e_start = 0, e_stop = 0, e_rand = 0;
    int len = eff_len(int'(list_len));
    key_pulse = k;
    play_done = d;
    @(posedge clk);
    if (!m_act) begin
      if (k) begin
        e_start = 1; m_act = 1; m_chain = 0;
        if (mode == 2'b00) begin
          m_idx = 0; m_chain = 1;
        end else if (mode == 2'b10) begin
          e_rand = 1;
        end else begin
          m_idx = (m_ptr >= len) ? 0 : m_ptr;
          m_ptr = (m_idx >= len - 1) ? 0 : m_idx + 1;
        end
      end
    end else if (k && toggle_en) begin
      e_stop = 1; m_act = 0;
    end else if (d) begin
      if (m_chain && m_idx != len - 1) begin
        e_start = 1; m_idx++;
      end else begin
        m_act = 0;
      end
    end
    @(negedge clk);
    key_pulse = 0;
    play_done = 0;
    vectors++;
    if (start_o !== e_start || stop_o !== e_stop) begin
      miscompares++;
      $display("FAIL %s strobes: actual start=%b stop=%b, expected start=%b stop=%b",
               tag, start_o, stop_o, e_start, e_stop);
    end
    if (e_rand) begin
      if (int'(start_idx) >= len) begin
        miscompares++;
        $display("FAIL %s shuffle index: actual %0d, expected below %0d", tag, start_idx, len);
      end
      m_idx = int'(start_idx);
    end else if (int'(start_idx) !== m_idx) begin
      miscompares++;
      $display("FAIL %s index: actual %0d, expected %0d", tag, start_idx, m_idx);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_act = 0; m_chain = 0; m_idx = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (start_o !== 1'b0 || stop_o !== 1'b0 || start_idx !== 5'd0) begin
      miscompares++;
      $display("FAIL R1 reset: actual start=%b stop=%b idx=%0d, expected 0 0 0",
               start_o, stop_o, start_idx);
    end
    rst = 1'b0;
    step(0, 0, "R1");

    // R4 step mode wraps through a list of 3; R2 start one cycle after the press
    for (int i = 0; i < 4; i++) begin
      step(1, 0, "R4");
      step(0, 0, "R2");
      step(0, 1, "R4");
    end
    // R9 mode 11 continues the same pointer
    mode = 2'b11;
    step(1, 0, "R9");
    step(0, 1, "R9");
    // R8 done while idle is ignored
    step(0, 1, "R8");

    // R3 chain over 4 entries, then a restart from 0
    mode = 2'b00; list_len = 6'd4;
    for (int r = 0; r < 2; r++) begin
      step(1, 0, "R3");
      for (int i = 0; i < 4; i++) begin
        step(0, 0, "R3");
        step(0, 1, "R3");
      end
    end
    // R7 press ignored mid-chain without toggle
    step(1, 0, "R7");
    step(1, 0, "R7");
    step(0, 1, "R7");
    step(1, 0, "R7");
    step(0, 1, "R7");
    step(0, 1, "R7");
    step(0, 1, "R7");
    // R6 toggle stops a chain; later done pulses start nothing
    toggle_en = 1'b1;
    step(1, 0, "R6");
    step(0, 1, "R6");
    step(1, 0, "R6");
    step(0, 1, "R6");
    // R8 press and done together while active: stop wins
    step(1, 0, "R8");
    step(1, 1, "R8");
    step(0, 1, "R8");

    // R5 shuffle, length 1 and length 0 (R9) give index 0; length 40 stays below 32
    mode = 2'b10; toggle_en = 1'b0;
    list_len = 6'd1;
    step(1, 0, "R5"); step(0, 1, "R5");
    list_len = 6'd0;
    step(1, 0, "R9"); step(0, 1, "R9");
    list_len = 6'd40;
    for (int i = 0; i < 20; i++) begin
      step(1, 0, "R9"); step(0, 1, "R9");
    end
    // R9 step mode with length 0 always plays 0
    mode = 2'b01; list_len = 6'd0;
    step(1, 0, "R9"); step(0, 1, "R9");
    step(1, 0, "R9"); step(0, 1, "R9");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit k, d;
      string tg;
      if (!m_act && ($urandom % 8) == 0) begin
        mode      = 2'($urandom % 4);
        list_len  = 6'($urandom % 40);
        toggle_en = 1'($urandom % 2);
      end
      k = (($urandom % 6) == 0);
      d = m_act ? (($urandom % 3) == 0) : (($urandom % 10) == 0);
      tg = (mode == 2'b00) ? "R3" : (mode == 2'b10) ? "R5" : "R4";
      if (m_act && k) tg = toggle_en ? "R6" : "R7";
      step(k, d, tg);
    end
    finish_run();
  end
endmodule